// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the control engine of one linked-list DMA channel. Software supplies a head pointer and a one-cycle start pulse. From then on the walker fetches each 32-byte descriptor from memory, one 32-bit word at a time, over a valid/ready read port. It works out the transfer direction from which address field is zero and hands one command to an external data mover. When the mover reports completion, the walker writes a completion status word back into the descriptor and moves on to the descriptor named by the next pointer.

A descriptor is laid out as five fields at byte offsets 0, 4, 8, 16 and 24:

| Offset | Field |
|---|---|
| 0 | status (32 bits) |
| 4 | control (32 bits) |
| 8 | source address (64 bits) |
| 16 | destination address (64 bits) |
| 24 | next-descriptor address (64 bits) |

Only the low word of each 64-bit address is used. The list has no count and no null terminator. It ends when the walker fetches a descriptor whose status already carries the completed flag. Every descriptor must start on a 64-byte boundary. A misaligned pointer, or a descriptor whose source and destination are both zero, stops the channel and raises an error.

Top module: `desc_chain_walker`

## Requirements
- R1: While reset is asserted, and just after it is released, `busy`, `errFlag`, `rdValid`, `wrValid` and `cmdValid` are all low.
- R2: A start pulse with a 64-byte-aligned head sets `busy` from the next cycle. The walker then reads the eight words of the descriptor in order, at head+0, +4, ... +28, each read held until `rdReady`.
- R3: When the word read at offset 0 has bit 31 set, the walker halts right after that single read. It issues no further read, no command and no write, and `errFlag` stays low.
- R4: `cmdKind` encodes the transfer kind: 0 means memory-to-stream (source non-zero, destination zero), 1 means stream-to-memory (source zero), and 2 means memory-to-memory (both non-zero). `cmdSrc` and `cmdDst` carry the low address words, and the upper address words at offsets 12 and 20 have no effect on kind or addresses.
- R5: `cmdLen` equals control bits [23:0] plus one. `cmdFlag` equals control bit 30. Control bits 24 to 29 and 31 have no effect.
- R6: Exactly one command is issued per descriptor. Its fields stay stable until `cmdReady`, and the walker then waits for `moverDone`.
- R7: After `moverDone`, the walker writes 0x80000000 to the descriptor's base address. It then fetches the descriptor at the next pointer (offset 24).
- R8: For a stream-to-memory descriptor, each `pktDone` pulse causes one extra status write of 0x80000000 to the descriptor base, and the walker keeps waiting. For the other kinds, `pktDone` is ignored.
- R9: If `moverDone` comes in the same cycle as `pktDone`, or while a packet status write is still pending, exactly one end-of-descriptor write follows.
- R10: A head pointer with any of bits [5:0] set raises `errFlag` in the next cycle with no read, and `busy` stays low. A misaligned next pointer raises `errFlag` after the end write, with no read of it.
- R11: A descriptor with both low address words zero raises `errFlag` and halts with no command and no write.
- R12: A start pulse while `busy` is ignored. An accepted start clears `errFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin walking at `headPtr` |
| headPtr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | High while the list is being walked |
| errFlag | output | 1 | Misaligned pointer or malformed descriptor |
| rdValid | output | 1 | Word read request |
| rdAddr | output | 32 | Byte address of the word read |
| rdReady | input | 1 | Read accepted; `rdData` valid this cycle |
| rdData | input | 32 | Read data |
| wrValid | output | 1 | Status write request |
| wrAddr | output | 32 | Status write byte address |
| wrData | output | 32 | Status word written back |
| wrReady | input | 1 | Write accepted |
| cmdValid | output | 1 | Transfer command valid |
| cmdReady | input | 1 | Mover accepts the command |
| cmdKind | output | 2 | 0 memory-to-stream, 1 stream-to-memory, 2 memory-to-memory |
| cmdSrc | output | 32 | Source address |
| cmdDst | output | 32 | Destination address |
| cmdLen | output | 25 | Transfer length in bytes |
| cmdFlag | output | 1 | Per-descriptor flag (control bit 30) |
| moverDone | input | 1 | Mover finished the current command |
| pktDone | input | 1 | Mover stored one incoming packet |

## Verification
Two events can land in the same cycle: the mover's completion pulse and its packet-stored pulse on a stream-to-memory descriptor. A completion pulse can also arrive while the packet status write is stalled by a low `wrReady`. The mover model in the bench has one mode that pulses both inputs together. Another mode holds `wrReady` low after a packet pulse and sends completion while that write is pending. Both cases are judged by the number and addresses of status writes (one versus two) and by whether the walker still goes on to the terminating descriptor.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  typedef enum logic [1:0] {
    KIND_M2S = 2'd0,
    KIND_S2M = 2'd1,
    KIND_M2M = 2'd2
  } xferKind_t;

  typedef struct packed {
    logic loadHead;
    logic loadNext;
    logic capWord;
  } dpStrobe_t;

  localparam int WORDS_PER_DESC = 8;
  localparam int WORD_CTRL      = 1;
  localparam int WORD_SRC       = 2;
  localparam int WORD_DST       = 4;
  localparam int WORD_NEXT      = 6;

endpackage

// File: rtl/sgw_datapath.sv
module sgw_datapath
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int ALIGN_BITS = 6,
  parameter int DONE_BIT   = 31,
  parameter int FLAG_BIT   = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] headPtr,
  input  logic [31:0]       rdData,
  output logic [ADDR_W-1:0] descBase,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              idxFirst,
  output logic              idxLast,
  output logic              statusDone,
  output logic              headMisaligned,
  output logic              nextMisaligned,
  output logic              bothZero,
  output xferKind_t         kind,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [LEN_W:0]    byteCount,
  output logic              xferFlag
);

  localparam int IDX_W = $clog2(WORDS_PER_DESC);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] srcReg;
  logic [ADDR_W-1:0] dstReg;
  logic [ADDR_W-1:0] nextReg;
  logic [LEN_W-1:0]  lenField;
  logic              flagReg;

  // descriptor base and word index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      idx     <= '0;
    end else if (strobe.loadHead) begin
      baseReg <= headPtr;
      idx     <= '0;
    end else if (strobe.loadNext) begin
      baseReg <= nextReg;
      idx     <= '0;
    end else if (strobe.capWord) begin
      idx     <= idx + IDX_W'(1);
    end
  end

  // field capture: upper address words fall through uncaptured
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= '0;
      dstReg   <= '0;
      nextReg  <= '0;
      lenField <= '0;
      flagReg  <= 1'b0;
    end else if (strobe.capWord) begin
      if (idx == IDX_W'(WORD_CTRL)) begin
        lenField <= rdData[LEN_W-1:0];
        flagReg  <= rdData[FLAG_BIT];
      end
      if (idx == IDX_W'(WORD_SRC))  srcReg  <= rdData[ADDR_W-1:0];
      if (idx == IDX_W'(WORD_DST))  dstReg  <= rdData[ADDR_W-1:0];
      if (idx == IDX_W'(WORD_NEXT)) nextReg <= rdData[ADDR_W-1:0];
    end
  end

  assign descBase       = baseReg;
  assign rdAddr         = baseReg + {{(ADDR_W-IDX_W-2){1'b0}}, idx, 2'b00};
  assign idxFirst       = (idx == '0);
  assign idxLast        = (idx == IDX_W'(WORDS_PER_DESC-1));
  assign statusDone     = rdData[DONE_BIT];
  assign headMisaligned = |headPtr[ALIGN_BITS-1:0];
  assign nextMisaligned = |nextReg[ALIGN_BITS-1:0];
  assign bothZero       = (srcReg == '0) && (dstReg == '0);
  assign srcAddr        = srcReg;
  assign dstAddr        = dstReg;
  assign byteCount      = {1'b0, lenField} + {{LEN_W{1'b0}}, 1'b1};
  assign xferFlag       = flagReg;

  always_comb begin
    if (dstReg == '0)      kind = KIND_M2S;
    else if (srcReg == '0) kind = KIND_S2M;
    else                   kind = KIND_M2M;
  end

  // R10
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadNext || strobe.loadHead) |=> (descBase[ALIGN_BITS-1:0] == '0));

endmodule

// File: rtl/sgw_control.sv
module sgw_control
  import sgw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      headMisaligned,
  input  logic      nextMisaligned,
  input  logic      statusDone,
  input  logic      bothZero,
  input  logic      idxFirst,
  input  logic      idxLast,
  input  xferKind_t kind,
  input  logic      rdReady,
  input  logic      wrReady,
  input  logic      cmdReady,
  input  logic      moverDone,
  input  logic      pktDone,
  output dpStrobe_t strobe,
  output logic      rdValid,
  output logic      wrValid,
  output logic      cmdValid,
  output logic      busy,
  output logic      errFlag
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_ISSUE, ST_WAIT, ST_WB_PKT, ST_WB_END
  } walkState_t;

  walkState_t state, stateNext;
  logic errReg, errNext;
  logic pendDone, pendNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errReg   <= 1'b0;
      pendDone <= 1'b0;
    end else begin
      state    <= stateNext;
      errReg   <= errNext;
      pendDone <= pendNext;
    end
  end

  always_comb begin
    stateNext = state;
    errNext   = errReg;
    pendNext  = pendDone;
    strobe    = '0;
    rdValid   = 1'b0;
    wrValid   = 1'b0;
    cmdValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          if (headMisaligned) begin
            errNext = 1'b1;
          end else begin
            errNext         = 1'b0;
            strobe.loadHead = 1'b1;
            stateNext       = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        rdValid = 1'b1;
        if (rdReady) begin
          strobe.capWord = 1'b1;
          if (idxFirst && statusDone) stateNext = ST_IDLE;
          else if (idxLast)           stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (bothZero) begin
          errNext   = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cmdValid = 1'b1;
        if (cmdReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (moverDone)                         stateNext = ST_WB_END;
        else if (pktDone && kind == KIND_S2M)  stateNext = ST_WB_PKT;
      end
      ST_WB_PKT: begin
        wrValid = 1'b1;
        if (moverDone) pendNext = 1'b1;
        if (wrReady) begin
          if (pendDone || moverDone) begin
            pendNext  = 1'b0;
            stateNext = ST_WB_END;
          end else begin
            stateNext = ST_WAIT;
          end
        end
      end
      ST_WB_END: begin
        wrValid = 1'b1;
        if (wrReady) begin
          if (nextMisaligned) begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.loadNext = 1'b1;
            stateNext       = ST_FETCH;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign errFlag = errReg;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid);

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid);

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid);

  // R9
  pend_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendDone |-> (state == ST_WB_PKT));

  // R10
  err_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy);

  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, wrValid, cmdValid}));

endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int ALIGN_BITS = 6,
  parameter int DONE_BIT   = 31,
  parameter int FLAG_BIT   = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] headPtr,
  output logic              busy,
  output logic              errFlag,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic [31:0]       rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  input  logic              wrReady,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [1:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdSrc,
  output logic [ADDR_W-1:0] cmdDst,
  output logic [LEN_W:0]    cmdLen,
  output logic              cmdFlag,
  input  logic              moverDone,
  input  logic              pktDone
);

  localparam logic [31:0] STATUS_WORD = 32'(1) << DONE_BIT;

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] descBase;
  logic              idxFirst, idxLast, statusDone;
  logic              headMisaligned, nextMisaligned, bothZero;
  xferKind_t         kind;

  sgw_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS),
    .DONE_BIT(DONE_BIT), .FLAG_BIT(FLAG_BIT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headPtr(headPtr), .rdData(rdData),
    .descBase(descBase), .rdAddr(rdAddr), .idxFirst(idxFirst), .idxLast(idxLast),
    .statusDone(statusDone), .headMisaligned(headMisaligned),
    .nextMisaligned(nextMisaligned), .bothZero(bothZero), .kind(kind),
    .srcAddr(cmdSrc), .dstAddr(cmdDst), .byteCount(cmdLen), .xferFlag(cmdFlag)
  );

  sgw_control i_control (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .headMisaligned(headMisaligned), .nextMisaligned(nextMisaligned),
    .statusDone(statusDone), .bothZero(bothZero), .idxFirst(idxFirst),
    .idxLast(idxLast), .kind(kind), .rdReady(rdReady), .wrReady(wrReady),
    .cmdReady(cmdReady), .moverDone(moverDone), .pktDone(pktDone),
    .strobe(strobe), .rdValid(rdValid), .wrValid(wrValid), .cmdValid(cmdValid),
    .busy(busy), .errFlag(errFlag)
  );

  assign wrAddr  = descBase;
  assign wrData  = STATUS_WORD;
  assign cmdKind = kind;

  // R6
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> $stable(cmdSrc) && $stable(cmdDst) && $stable(cmdLen)
                              && $stable(cmdKind) && $stable(cmdFlag));

  // R7
  wr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr[ALIGN_BITS-1:0] == '0));

endmodule

// File: tb/test_desc_chain_walker.sv
`timescale 1ns/1ps
module test_desc_chain_walker;

  localparam logic [31:0] DONE = 32'h8000_0000;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] srcHi;
    logic [31:0] dst;
    logic [31:0] dstHi;
    logic [31:0] ctrl;
    logic        expErr;
    logic [1:0]  expKind;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{src:32'h1000, srcHi:32'h0, dst:32'h0, dstHi:32'h0, ctrl:32'h0000_00FF, expErr:1'b0, expKind:2'd0},
    '{src:32'h0, srcHi:32'h0, dst:32'h2000, dstHi:32'h0, ctrl:32'h4000_0003, expErr:1'b0, expKind:2'd1},
    '{src:32'h3000, srcHi:32'hDEAD_BEEF, dst:32'h4000, dstHi:32'h0, ctrl:32'h3F00_0010, expErr:1'b0, expKind:2'd2},
    '{src:32'h0, srcHi:32'h1234_0000, dst:32'h0, dstHi:32'h0, ctrl:32'h0000_0005, expErr:1'b1, expKind:2'd0},
    '{src:32'h10, srcHi:32'h0, dst:32'h0, dstHi:32'h0, ctrl:32'hC0FF_FFFF, expErr:1'b0, expKind:2'd0},
    '{src:32'h5, srcHi:32'h0, dst:32'h0, dstHi:32'hFFFF_FFFF, ctrl:32'h0000_0000, expErr:1'b0, expKind:2'd0}
  };

  logic        clk = 1'b0;
  logic        rstN, startPulse;
  logic [31:0] headPtr;
  logic        busy, errFlag;
  logic        rdValid, rdReady, wrValid, wrReady, cmdValid, cmdReady;
  logic [31:0] rdAddr, rdData, wrAddr, wrData, cmdSrc, cmdDst;
  logic [1:0]  cmdKind;
  logic [24:0] cmdLen;
  logic        cmdFlag, moverDone, pktDone;

  logic [31:0] mem [0:255];
  int          checkCount = 0, failCount = 0;
  bit          finished = 1'b0;

  int          rdCount, wrCount, cmdCount;
  logic [31:0] rdLog [0:63];
  logic [31:0] wrAddrLog [0:15];
  logic [31:0] wrDataLog [0:15];
  logic [31:0] cSrc, cDst;
  logic [24:0] cLen;
  logic [1:0]  cKind;
  logic        cFlag;
  int          moverMode, moverDelay, mvCnt, mvPhase, cyc;
  bit          mvActive, wrHold;

  always #2 clk = ~clk;

  assign rdData = mem[rdAddr[9:2]];

  desc_chain_walker i_desc_chain_walker (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .headPtr(headPtr),
    .busy(busy), .errFlag(errFlag), .rdValid(rdValid), .rdAddr(rdAddr),
    .rdReady(rdReady), .rdData(rdData), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrReady(wrReady), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdSrc(cmdSrc), .cmdDst(cmdDst), .cmdLen(cmdLen),
    .cmdFlag(cmdFlag), .moverDone(moverDone), .pktDone(pktDone)
  );

  task automatic checkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory, status-write and mover models, driven at the falling edge
  initial begin
    rdReady = 0; wrReady = 0; cmdReady = 0; moverDone = 0; pktDone = 0;
    cyc = 0; mvActive = 0; wrHold = 0; mvPhase = 0; mvCnt = 0;
    rdCount = 0; wrCount = 0; cmdCount = 0;
    forever begin
      @(negedge clk);
      cyc++;
      moverDone = 0;
      pktDone   = 0;
      rdReady   = (cyc % 3) != 1;
      cmdReady  = (cyc % 2) == 0;
      if (mvActive) begin
        if (mvPhase == 1) begin
          if (wrValid) begin moverDone = 1; mvPhase = 2; end
        end else if (mvPhase == 2) begin
          wrHold = 0; mvActive = 0; mvPhase = 0;
        end else if (mvCnt == 0) begin
          case (moverMode)
            2: begin pktDone = 1; moverDone = 1; mvActive = 0; end
            3: begin pktDone = 1; wrHold = 1; mvPhase = 1; end
            default: begin moverDone = 1; mvActive = 0; end
          endcase
        end else begin
          if (moverMode == 1 && mvCnt == 2) pktDone = 1;
          mvCnt--;
        end
      end
      wrReady = !wrHold && ((cyc % 4) != 2);
      if (rdValid && rdReady) begin
        if (rdCount < 64) rdLog[rdCount] = rdAddr;
        rdCount++;
      end
      if (wrValid && wrReady) begin
        if (wrCount < 16) begin wrAddrLog[wrCount] = wrAddr; wrDataLog[wrCount] = wrData; end
        wrCount++;
        mem[wrAddr[9:2]] = wrData;
      end
      if (cmdValid && cmdReady) begin
        cSrc = cmdSrc; cDst = cmdDst; cLen = cmdLen; cKind = cmdKind; cFlag = cmdFlag;
        cmdCount++;
        mvActive = 1; mvCnt = moverDelay; mvPhase = 0;
      end
    end
  end

  task automatic clearAll();
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    rdCount = 0; wrCount = 0; cmdCount = 0;
  endtask

  task automatic putDesc(input logic [31:0] b, input logic [31:0] st, input logic [31:0] ct,
                         input logic [31:0] s, input logic [31:0] sh, input logic [31:0] d,
                         input logic [31:0] dh, input logic [31:0] nx);
    mem[b[9:2]+0] = st; mem[b[9:2]+1] = ct;
    mem[b[9:2]+2] = s;  mem[b[9:2]+3] = sh;
    mem[b[9:2]+4] = d;  mem[b[9:2]+5] = dh;
    mem[b[9:2]+6] = nx; mem[b[9:2]+7] = 32'h0;
  endtask

  task automatic startChain(input logic [31:0] h);
    @(negedge clk);
    headPtr = h; startPulse = 1;
    @(negedge clk);
    startPulse = 0;
  endtask

  task automatic waitHalt();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runS2M(input int mode);
    clearAll();
    putDesc(32'h40, 0, 32'h0000_0007, 0, 0, 32'h900, 0, 32'h80);
    putDesc(32'h80, DONE, 0, 0, 0, 0, 0, 0);
    moverMode = mode; moverDelay = 3;
    startChain(32'h40);
    waitHalt();
  endtask

  initial begin
    rstN = 0; startPulse = 0; headPtr = 0; moverMode = 0; moverDelay = 3;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1 busy in reset", busy, 0);
    checkEq("R1 err in reset", errFlag, 0);
    checkEq("R1 valids in reset", {rdValid, wrValid, cmdValid}, 0);
    rstN = 1;
    @(negedge clk);
    checkEq("R1 idle after reset", {busy, errFlag, rdValid, wrValid, cmdValid}, 0);

    // vector table: one descriptor followed by a completed terminator
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      bit orderOk;
      v = VECS[i];
      clearAll();
      putDesc(32'h40, 0, v.ctrl, v.src, v.srcHi, v.dst, v.dstHi, 32'h80);
      putDesc(32'h80, DONE, 0, 0, 0, 0, 0, 0);
      moverMode = 0; moverDelay = 3;
      startChain(32'h40);
      checkEq("R2 busy after start", busy, 1);
      waitHalt();
      orderOk = 1;
      for (int k = 0; k < 8; k++) if (rdLog[k] !== 32'h40 + 4*k) orderOk = 0;
      checkEq("R2 read order", orderOk, 1);
      if (v.expErr) begin
        checkEq("R11 err on zero addresses", errFlag, 1);
        checkEq("R11 no command", cmdCount, 0);
        checkEq("R11 no write", wrCount, 0);
        checkEq("R11 reads", rdCount, 8);
      end else begin
        checkEq("R12 err clear after accepted start", errFlag, 0);
        checkEq("R6 one command", cmdCount, 1);
        checkEq("R4 kind", cKind, v.expKind);
        checkEq("R4 src low word", cSrc, v.src);
        checkEq("R4 dst low word", cDst, v.dst);
        checkEq("R5 length", cLen, {1'b0, v.ctrl[23:0]} + 25'd1);
        checkEq("R5 flag", cFlag, v.ctrl[30]);
        checkEq("R7 one write", wrCount, 1);
        checkEq("R7 write addr", wrAddrLog[0], 32'h40);
        checkEq("R7 write data", wrDataLog[0], DONE);
        checkEq("R7 follows next", rdCount, 9);
        checkEq("R7 next read addr", rdLog[8], 32'h80);
      end
      checkEq("R2 busy low at halt", busy, 0);
    end

    // R7 three-descriptor chain
    clearAll();
    putDesc(32'h100, 0, 32'h1F, 32'hA00, 0, 0, 0, 32'h140);
    putDesc(32'h140, 0, 32'h2F, 0, 0, 32'hB00, 0, 32'h180);
    putDesc(32'h180, 0, 32'h3F, 32'hC00, 0, 32'hD00, 0, 32'h1C0);
    putDesc(32'h1C0, DONE, 0, 0, 0, 0, 0, 0);
    moverMode = 0; moverDelay = 4;
    startChain(32'h100);
    waitHalt();
    checkEq("R7 chain commands", cmdCount, 3);
    checkEq("R7 chain writes", wrCount, 3);
    checkEq("R7 chain write addrs", {wrAddrLog[0], wrAddrLog[1], wrAddrLog[2]},
            {32'h100, 32'h140, 32'h180} & 96'hFFFFFFFF_FFFFFFFF);
    checkEq("R7 chain last write", wrAddrLog[2], 32'h180);
    checkEq("R7 chain reads", rdCount, 25);
    checkEq("R7 last command kind", cKind, 2'd2);

    // R3 head already completed
    clearAll();
    putDesc(32'h200, DONE | 32'h5, 32'h1, 32'h111, 0, 0, 0, 32'h240);
    startChain(32'h200);
    waitHalt();
    checkEq("R3 single read", rdCount, 1);
    checkEq("R3 no command", cmdCount, 0);
    checkEq("R3 no write", wrCount, 0);
    checkEq("R3 no error", errFlag, 0);

    // R10 misaligned head
    clearAll();
    startChain(32'h44);
    checkEq("R10 err next cycle", errFlag, 1);
    checkEq("R10 busy stays low", busy, 0);
    waitHalt();
    checkEq("R10 no read on bad head", rdCount, 0);

    // R10 misaligned next pointer
    clearAll();
    putDesc(32'h240, 0, 32'h3, 32'h700, 0, 0, 0, 32'h284);
    startChain(32'h240);
    waitHalt();
    checkEq("R10 bad next command", cmdCount, 1);
    checkEq("R10 bad next write", wrCount, 1);
    checkEq("R10 bad next reads", rdCount, 8);
    checkEq("R10 bad next err", errFlag, 1);

    // R8 packet writeback on stream-to-memory
    runS2M(1);
    checkEq("R8 packet plus end writes", wrCount, 2);
    checkEq("R8 packet write addr", wrAddrLog[0], 32'h40);
    checkEq("R8 end write addr", wrAddrLog[1], 32'h40);
    checkEq("R8 continues to terminator", rdCount, 9);

    // R8 packet pulse ignored for memory-to-stream
    clearAll();
    putDesc(32'h40, 0, 32'h7, 32'h900, 0, 0, 0, 32'h80);
    putDesc(32'h80, DONE, 0, 0, 0, 0, 0, 0);
    moverMode = 1; moverDelay = 3;
    startChain(32'h40);
    waitHalt();
    checkEq("R8 pkt ignored for M2S", wrCount, 1);

    // R9 done and packet in the same cycle
    runS2M(2);
    checkEq("R9 coincident single write", wrCount, 1);
    checkEq("R9 coincident reads", rdCount, 9);

    // R9 done while packet write stalled
    runS2M(3);
    checkEq("R9 stalled packet then end", wrCount, 2);
    checkEq("R9 stalled reads", rdCount, 9);
    checkEq("R9 no error", errFlag, 0);

    // R12 start while busy ignored
    clearAll();
    putDesc(32'h40, 0, 32'h7, 32'h900, 0, 0, 0, 32'h80);
    putDesc(32'h80, DONE, 0, 0, 0, 0, 0, 0);
    moverMode = 0; moverDelay = 20;
    startChain(32'h40);
    repeat (12) @(negedge clk);
    checkEq("R12 busy before second start", busy, 1);
    startChain(32'h44);
    waitHalt();
    checkEq("R12 second start ignored err", errFlag, 0);
    checkEq("R12 second start ignored reads", rdCount, 9);
    checkEq("R12 single command", cmdCount, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=hung expected=halt");
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

endmodule